// File: doc/BRIEF.md
# USB IN Endpoint Transmit Handler

This block is the transmit half of a device-side USB endpoint engine in which one byte buffer serves all sixteen IN endpoints. Firmware pushes payload bytes into a 64-byte FIFO through a data write port. It then writes a control word that names the endpoint allowed to take that buffer. When the token decoder reports an IN token, the block answers one cycle later with a handshake decision. The answer is STALL if that endpoint is stalled, NAK if the endpoint is not the armed one, and DATA otherwise. A DATA answer is followed by the payload and a two-byte CRC16 on a valid/ready byte stream.

After the packet the block waits for the host outcome. An ACK empties the buffer, disarms it and raises a done event. A lost handshake rewinds the read side so that the same packet can go out again. A sixteen-entry stall map, which SETUP tokens can clear, overrides any data answer. The done event has a pending flag and an enable flag that together drive the interrupt line.

Top module: `usb_in_xmit`

## Requirements
- R1: The FIFO holds 64 bytes. Each `data_wr` appends one byte, and bytes leave in write order. A write to a full FIFO is dropped, and a write raises `stat_have` on the next cycle.
- R2: `resp_valid` pulses in the cycle after an accepted IN token. With nothing armed, `resp_kind` is 0 (NAK) and no byte stream follows.
- R3: A control write with bit 5 = 0 and bit 6 = 0 arms the buffer for the endpoint in bits [3:0]. An IN token to that endpoint gets `resp_kind` 2 (DATA), followed by every FIFO byte in order on `tx_data`. A byte counts as transferred when `tx_valid` and `tx_ready` are both high.
- R4: If the buffer is armed while the FIFO is empty, the block sends a zero-length packet made of only the two CRC bytes, 0x00 0x00.
- R5: Each DATA packet ends with the CRC16: polynomial 0x8005, processed LSB first, seed 0xFFFF, remainder inverted, low byte first. `tx_last` marks the final CRC byte, so a packet carries the payload length plus 2 bytes.
- R6: An IN token to an endpoint other than the armed one gets NAK, and the armed payload stays intact for the armed endpoint.
- R7: If `hs_lost` is asserted after a packet, the buffer stays armed and the next IN token resends an identical packet.
- R8: If `hs_ack` is asserted after a packet, then on the next cycle the FIFO is empty and the buffer is disarmed (`stat_idle` = 1, `stat_have` = 0), and `ev_pend` is set.
- R9: `pend_wr` with `pend_wdata` = 1 clears `ev_pend`; with `pend_wdata` = 0 it has no effect. `irq` is high exactly when `ev_pend` and the enable bit written through `en_wr`/`en_wdata` are both 1. A new done event takes priority over a clear in the same cycle.
- R10: A control write with bit 6 = 1 (and bit 5 = 0) stalls the endpoint in bits [3:0] without arming the buffer or changing an existing arming. A stalled endpoint answers IN tokens with `resp_kind` 1 (STALL), even when it is the armed one. A write with bit 6 = 0 clears the stall of the endpoint it arms.
- R11: A SETUP token clears the stall flag of its endpoint.
- R12: A control write with bit 5 = 1 empties the FIFO, disarms the buffer and abandons any packet in progress.
- R13: After reset, `stat_idle` = 1 and `stat_have`, `ev_pend`, `irq`, `resp_valid` and `tx_valid` are 0. `stat_idle` is 1 whenever nothing is armed, and `stat_have` is 1 whenever the FIFO holds a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| data_wr | input | 1 | Append `data_wdata` to the FIFO |
| data_wdata | input | 8 | Payload byte |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 8 | [3:0] endpoint, [5] flush, [6] stall |
| pend_wr | input | 1 | Pending flag write strobe |
| pend_wdata | input | 1 | 1 clears the pending flag |
| en_wr | input | 1 | Event enable write strobe |
| en_wdata | input | 1 | New event enable value |
| in_tok_valid | input | 1 | Decoded IN token present |
| in_tok_ep | input | EPW | Endpoint of the IN token |
| setup_tok_valid | input | 1 | Decoded SETUP token present |
| setup_tok_ep | input | EPW | Endpoint of the SETUP token |
| resp_valid | output | 1 | Handshake decision strobe |
| resp_kind | output | 2 | 0 NAK, 1 STALL, 2 DATA |
| tx_valid | output | 1 | Packet byte available |
| tx_data | output | 8 | Packet byte |
| tx_last | output | 1 | Final CRC byte of the packet |
| tx_ready | input | 1 | Serializer accepts the byte |
| hs_ack | input | 1 | Host acknowledged the packet |
| hs_lost | input | 1 | Host handshake missing or bad |
| stat_idle | output | 1 | Nothing armed |
| stat_have | output | 1 | FIFO holds at least one byte |
| ev_pend | output | 1 | Done event pending |
| irq | output | 1 | Interrupt request |

## Verification
The assertions hold at every cycle the local rules that need no payload knowledge. A DATA answer only follows an armed buffer, and a NAK or STALL answer never starts a stream. An ACK always leaves the buffer empty and disarmed, and the pending flag only rises after an ACK. A SETUP token always clears its stall bit, and a write always raises the have flag. What only the bench scenarios can show are the properties of whole packets: that the bytes come out in order and intact across every payload length from 0 to 64, and that the CRC residue is correct. They also show that a packet after a lost handshake is identical to the first one, and that a wrong-endpoint NAK or a stall leaves the armed payload untouched.

// File: rtl/usb_in_pkg.sv
package usb_in_pkg;

    localparam int FIFO_DEPTH     = 64;
    localparam int EP_W           = 4;
    localparam int BYTE_W         = 8;
    localparam int CTRL_FLUSH_BIT = 5;
    localparam int CTRL_STALL_BIT = 6;
    localparam logic [15:0] CRC_SEED    = 16'hFFFF;
    localparam logic [15:0] CRC_POLY_RF = 16'hA001;   // 0x8005 bit-reversed

    typedef enum logic [1:0] {
        HS_NAK   = 2'd0,
        HS_STALL = 2'd1,
        HS_DATA  = 2'd2
    } resp_e;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_DATA,
        TX_CRC_LO,
        TX_CRC_HI,
        TX_WAIT
    } tx_state_e;

    typedef struct packed {
        logic flush;
        logic stall;
    } ctrl_cmd_t;

    function automatic ctrl_cmd_t decode_ctrl(input logic [BYTE_W-1:0] w);
        ctrl_cmd_t c;
        c.flush = w[CTRL_FLUSH_BIT];
        c.stall = w[CTRL_STALL_BIT];
        return c;
    endfunction

    // One byte through the reflected CRC16 register, LSB first.
    function automatic logic [15:0] crc16_step(input logic [15:0] crc_in,
                                               input logic [BYTE_W-1:0] d);
        logic [15:0] c;
        c = crc_in;
        for (int b = 0; b < BYTE_W; b++) begin
            if (c[0] ^ d[b]) c = (c >> 1) ^ CRC_POLY_RF;
            else             c = c >> 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/usb_in_fifo.sv
module usb_in_fifo #(
    parameter int DEPTH = 64,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          flush,
    input  logic          rd_adv,
    input  logic          rewind,
    output logic [DW-1:0] rd_data,
    output logic          empty,
    output logic          have
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_cnt;
    logic [PW-1:0] rd_cnt;
    logic          full;
    logic          do_wr;

    assign full  = (wr_cnt == PW'(DEPTH));
    assign do_wr = wr_en && !full && !flush;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_cnt <= '0;
            rd_cnt <= '0;
        end else begin
            if (do_wr) wr_cnt <= wr_cnt + 1'b1;
            // A packet always starts at entry zero, so a rewind returns there.
            if (rewind)      rd_cnt <= '0;
            else if (rd_adv) rd_cnt <= rd_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_cnt[AW-1:0]] <= wr_data;
    end

    assign rd_data = mem[rd_cnt[AW-1:0]];
    assign empty   = (rd_cnt == wr_cnt);
    assign have    = (wr_cnt != '0);

endmodule

// File: rtl/usb_in_crc16.sv
module usb_in_crc16 import usb_in_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              init,
    input  logic              adv,
    input  logic [BYTE_W-1:0] data,
    output logic [15:0]       crc_out
);
    logic [15:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || init)  crc_q <= CRC_SEED;
        else if (adv)     crc_q <= crc16_step(crc_q, data);
    end

    assign crc_out = ~crc_q;

endmodule

// File: rtl/usb_in_stall_map.sv
module usb_in_stall_map #(
    parameter int EPW = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                set_valid,
    input  logic [EPW-1:0]      set_ep,
    input  logic                set_val,
    input  logic                clr_valid,
    input  logic [EPW-1:0]      clr_ep,
    output logic [(1<<EPW)-1:0] stall_vec
);
    localparam int EP_NUM = 1 << EPW;

    for (genvar g = 0; g < EP_NUM; g++) begin : g_ep
        always_ff @(posedge clk) begin
            if (rst)                                      stall_vec[g] <= 1'b0;
            else if (clr_valid && clr_ep == EPW'(g))      stall_vec[g] <= 1'b0;
            else if (set_valid && set_ep == EPW'(g))      stall_vec[g] <= set_val;
        end
    end

endmodule

// File: rtl/usb_in_xmit.sv
module usb_in_xmit import usb_in_pkg::*; #(
    parameter int DEPTH = FIFO_DEPTH,
    parameter int EPW   = EP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] data_wdata,
    input  logic              ctrl_wr,
    input  logic [BYTE_W-1:0] ctrl_wdata,
    input  logic              pend_wr,
    input  logic              pend_wdata,
    input  logic              en_wr,
    input  logic              en_wdata,
    input  logic              in_tok_valid,
    input  logic [EPW-1:0]    in_tok_ep,
    input  logic              setup_tok_valid,
    input  logic [EPW-1:0]    setup_tok_ep,
    output logic              resp_valid,
    output logic [1:0]        resp_kind,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_last,
    input  logic              tx_ready,
    input  logic              hs_ack,
    input  logic              hs_lost,
    output logic              stat_idle,
    output logic              stat_have,
    output logic              ev_pend,
    output logic              irq
);
    localparam int EP_NUM = 1 << EPW;

    tx_state_e         state, nxt;
    ctrl_cmd_t         cmd;
    logic              ctrl_flush, ctrl_stall_wr, ctrl_arm;
    logic              armed;
    logic [EPW-1:0]    armed_ep;
    logic [EP_NUM-1:0] stall_vec;
    resp_e             kind;
    logic              tok_take, pkt_start;
    logic              ack_done, lost_done;
    logic              fifo_empty, fifo_have, fifo_flush;
    logic [BYTE_W-1:0] fifo_rd;
    logic              rd_adv, crc_adv;
    logic [15:0]       crc_val;
    logic              ev_en;
    logic              unused_ctrl;

    assign unused_ctrl   = ^{ctrl_wdata[BYTE_W-1], ctrl_wdata[4]};

    // Control word decode
    assign cmd           = decode_ctrl(ctrl_wdata);
    assign ctrl_flush    = ctrl_wr && cmd.flush;
    assign ctrl_stall_wr = ctrl_wr && !cmd.flush;
    assign ctrl_arm      = ctrl_wr && !cmd.flush && !cmd.stall;

    // Host outcome while waiting for the handshake
    assign ack_done   = (state == TX_WAIT) && hs_ack;
    assign lost_done  = (state == TX_WAIT) && hs_lost && !hs_ack;
    assign fifo_flush = ctrl_flush || ack_done;

    // Token decision: stall beats data, data only for the armed endpoint
    always_comb begin
        if (stall_vec[in_tok_ep])                 kind = HS_STALL;
        else if (armed && armed_ep == in_tok_ep)  kind = HS_DATA;
        else                                      kind = HS_NAK;
    end

    assign tok_take  = in_tok_valid && (state == TX_IDLE) && !ctrl_flush;
    assign pkt_start = tok_take && (kind == HS_DATA);

    usb_in_fifo #(.DEPTH(DEPTH), .DW(BYTE_W)) i_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (data_wr),
        .wr_data (data_wdata),
        .flush   (fifo_flush),
        .rd_adv  (rd_adv),
        .rewind  (lost_done),
        .rd_data (fifo_rd),
        .empty   (fifo_empty),
        .have    (fifo_have)
    );

    usb_in_crc16 i_crc (
        .clk     (clk),
        .rst     (rst),
        .init    (pkt_start),
        .adv     (crc_adv),
        .data    (fifo_rd),
        .crc_out (crc_val)
    );

    usb_in_stall_map #(.EPW(EPW)) i_stall (
        .clk       (clk),
        .rst       (rst),
        .set_valid (ctrl_stall_wr),
        .set_ep    (ctrl_wdata[EPW-1:0]),
        .set_val   (cmd.stall),
        .clr_valid (setup_tok_valid),
        .clr_ep    (setup_tok_ep),
        .stall_vec (stall_vec)
    );

    // Arming
    always_ff @(posedge clk) begin
        if (rst || ctrl_flush || ack_done) begin
            armed    <= 1'b0;
            armed_ep <= '0;
        end else if (ctrl_arm) begin
            armed    <= 1'b1;
            armed_ep <= ctrl_wdata[EPW-1:0];
        end
    end

    // Packet sequencer
    always_comb begin
        nxt      = state;
        tx_valid = 1'b0;
        tx_data  = '0;
        tx_last  = 1'b0;
        rd_adv   = 1'b0;
        crc_adv  = 1'b0;
        unique case (state)
            TX_IDLE: begin
                if (pkt_start) nxt = TX_DATA;
            end
            TX_DATA: begin
                if (fifo_empty) begin
                    nxt = TX_CRC_LO;
                end else begin
                    tx_valid = 1'b1;
                    tx_data  = fifo_rd;
                    if (tx_ready) begin
                        rd_adv  = 1'b1;
                        crc_adv = 1'b1;
                    end
                end
            end
            TX_CRC_LO: begin
                tx_valid = 1'b1;
                tx_data  = crc_val[7:0];
                if (tx_ready) nxt = TX_CRC_HI;
            end
            TX_CRC_HI: begin
                tx_valid = 1'b1;
                tx_data  = crc_val[15:8];
                tx_last  = 1'b1;
                if (tx_ready) nxt = TX_WAIT;
            end
            TX_WAIT: begin
                if (hs_ack || hs_lost) nxt = TX_IDLE;
            end
            default: nxt = TX_IDLE;
        endcase
        if (ctrl_flush) nxt = TX_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) state <= TX_IDLE;
        else     state <= nxt;
    end

    // Handshake decision register
    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_kind  <= HS_NAK;
        end else begin
            resp_valid <= tok_take;
            if (tok_take) resp_kind <= kind;
        end
    end

    // Done event
    always_ff @(posedge clk) begin
        if (rst)                          ev_pend <= 1'b0;
        else if (ack_done)                ev_pend <= 1'b1;
        else if (pend_wr && pend_wdata)   ev_pend <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)        ev_en <= 1'b0;
        else if (en_wr) ev_en <= en_wdata;
    end

    assign irq       = ev_pend && ev_en;
    assign stat_idle = !armed;
    assign stat_have = fifo_have;

endmodule

// File: rtl/usb_in_xmit_chk.sv
module usb_in_xmit_chk import usb_in_pkg::*; #(
    parameter int EPW = EP_W
) (
    input logic                clk,
    input logic                rst,
    input logic                data_wr,
    input logic                flush_wr,
    input logic                setup_tok_valid,
    input logic [EPW-1:0]      setup_tok_ep,
    input logic                resp_valid,
    input logic [1:0]          resp_kind,
    input logic                hs_ack,
    input logic                stat_idle,
    input logic                stat_have,
    input logic                ev_pend,
    input tx_state_e           st,
    input logic [(1<<EPW)-1:0] stall_vec
);

    // R1
    write_sets_have_chk: assert property (@(posedge clk) disable iff (rst)
        (data_wr && !flush_wr && !(st == TX_WAIT && hs_ack)) |=> stat_have);

    // R2
    no_stream_after_refusal_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_kind != HS_DATA) |-> (st == TX_IDLE));

    // R3
    data_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_kind == HS_DATA) |-> $past(!stat_idle));

    // R8
    ack_empties_chk: assert property (@(posedge clk) disable iff (rst)
        (st == TX_WAIT && hs_ack) |=> (stat_idle && !stat_have && ev_pend));

    // R9
    pend_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ev_pend) |-> $past(st == TX_WAIT && hs_ack));

    // R11
    setup_unstalls_chk: assert property (@(posedge clk) disable iff (rst)
        setup_tok_valid |=> !stall_vec[$past(setup_tok_ep)]);

endmodule

bind usb_in_xmit usb_in_xmit_chk #(.EPW(EPW)) i_chk (
    .clk             (clk),
    .rst             (rst),
    .data_wr         (data_wr),
    .flush_wr        (ctrl_flush),
    .setup_tok_valid (setup_tok_valid),
    .setup_tok_ep    (setup_tok_ep),
    .resp_valid      (resp_valid),
    .resp_kind       (resp_kind),
    .hs_ack          (hs_ack),
    .stat_idle       (stat_idle),
    .stat_have       (stat_have),
    .ev_pend         (ev_pend),
    .st              (state),
    .stall_vec       (stall_vec)
);

// File: tb/test_usb_in_xmit.sv
module test_usb_in_xmit;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       data_wr = 0;
    logic [7:0] data_wdata = 0;
    logic       ctrl_wr = 0;
    logic [7:0] ctrl_wdata = 0;
    logic       pend_wr = 0, pend_wdata = 0, en_wr = 0, en_wdata = 0;
    logic       in_tok_valid = 0;
    logic [3:0] in_tok_ep = 0;
    logic       setup_tok_valid = 0;
    logic [3:0] setup_tok_ep = 0;
    logic       resp_valid;
    logic [1:0] resp_kind;
    logic       tx_valid, tx_last;
    logic [7:0] tx_data;
    logic       tx_ready = 0;
    logic       hs_ack = 0, hs_lost = 0;
    logic       stat_idle, stat_have, ev_pend, irq;

    int checks = 0;
    int fails  = 0;
    logic [7:0] rx [0:79];
    logic [7:0] rx_prev [0:79];

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_in_xmit i_usb_in_xmit (
        .clk(clk), .rst(rst),
        .data_wr(data_wr), .data_wdata(data_wdata),
        .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .pend_wr(pend_wr), .pend_wdata(pend_wdata),
        .en_wr(en_wr), .en_wdata(en_wdata),
        .in_tok_valid(in_tok_valid), .in_tok_ep(in_tok_ep),
        .setup_tok_valid(setup_tok_valid), .setup_tok_ep(setup_tok_ep),
        .resp_valid(resp_valid), .resp_kind(resp_kind),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .tx_ready(tx_ready), .hs_ack(hs_ack), .hs_lost(hs_lost),
        .stat_idle(stat_idle), .stat_have(stat_have),
        .ev_pend(ev_pend), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int len, input int i);
        return 8'((len * 7 + i * 13 + 5) & 8'hFF);
    endfunction

    // Reflected CRC16 residue over payload plus CRC; a good packet leaves 0xB001.
    function automatic logic [15:0] residue(input int n);
        logic [15:0] c = 16'hFFFF;
        for (int k = 0; k < n; k++)
            for (int b = 0; b < 8; b++) begin
                if (c[0] ^ rx[k][b]) c = (c >> 1) ^ 16'hA001;
                else                 c = c >> 1;
            end
        return c;
    endfunction

    task automatic put(input logic [7:0] b);
        data_wr = 1; data_wdata = b;
        @(negedge clk);
        data_wr = 0;
    endtask

    task automatic ctl(input logic [3:0] ep, input bit flush, input bit stall);
        ctrl_wr = 1; ctrl_wdata = {1'b0, stall, flush, 1'b0, ep};
        @(negedge clk);
        ctrl_wr = 0;
    endtask

    task automatic token(input logic [3:0] ep, output bit got, output logic [1:0] kind);
        in_tok_valid = 1; in_tok_ep = ep;
        @(negedge clk);
        in_tok_valid = 0;
        got  = resp_valid;
        kind = resp_kind;
    endtask

    task automatic setup(input logic [3:0] ep);
        setup_tok_valid = 1; setup_tok_ep = ep;
        @(negedge clk);
        setup_tok_valid = 0;
    endtask

    task automatic collect(input int seed, output int n);
        bit done = 0;
        int guard = 0;
        n = 0;
        while (!done && guard < 1000) begin
            tx_ready = ((guard + seed) % 4) != 0;
            if (tx_valid && tx_ready) begin
                if (n < 80) rx[n] = tx_data;
                n++;
                done = tx_last;
            end
            @(negedge clk);
            guard++;
        end
        tx_ready = 0;
    endtask

    task automatic handshake(input bit ack);
        hs_ack = ack; hs_lost = !ack;
        @(negedge clk);
        hs_ack = 0; hs_lost = 0;
    endtask

    // Sends an IN token that must get DATA, then checks the whole packet.
    task automatic expect_packet(input logic [3:0] ep, input int len, input int seed,
                                 input string tag, output int n);
        bit got;
        logic [1:0] kind;
        token(ep, got, kind);
        chk(got && kind == 2'd2, {tag, " data answer"}, int'(kind), 2);
        collect(seed, n);
        chk(n == len + 2, {tag, " R5 packet length"}, n, len + 2);
        for (int i = 0; i < len && i < 64; i++)
            if (rx[i] !== pat(len, i)) chk(0, {tag, " R3 payload byte"}, rx[i], pat(len, i));
        chk(residue(n) == 16'hB001, {tag, " R5 crc residue"}, residue(n), 16'hB001);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        bit got;
        logic [1:0] kind;
        int n;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R13 reset state
        chk(stat_idle == 1, "R13 idle after reset", stat_idle, 1);
        chk(stat_have == 0, "R13 have after reset", stat_have, 0);
        chk(ev_pend == 0 && irq == 0, "R13 event after reset", {ev_pend, irq}, 0);
        chk(resp_valid == 0 && tx_valid == 0, "R13 outputs after reset", {resp_valid, tx_valid}, 0);

        // R2 every endpoint NAKs while unarmed
        for (int e = 0; e < 16; e++) begin
            token(4'(e), got, kind);
            chk(got && kind == 2'd0, "R2 unarmed NAK", {got, kind}, 4);
            chk(tx_valid == 0, "R2 no stream after NAK", tx_valid, 0);
        end

        // Sweep of payload lengths 0..64
        for (int len = 0; len <= 64; len++) begin
            logic [3:0] ep = 4'(len % 16);
            for (int i = 0; i < len; i++) put(pat(len, i));
            chk(stat_have == (len > 0), "R13 have after load", stat_have, len > 0);
            chk(stat_idle == 1, "R13 idle before arm", stat_idle, 1);
            ctl(ep, 0, 0);
            chk(stat_idle == 0, "R3 armed", stat_idle, 0);
            token(ep + 4'd1, got, kind);
            chk(got && kind == 2'd0, "R6 other endpoint NAK", kind, 0);
            expect_packet(ep, len, len, "sweep", n);
            if (len == 0)
                chk(rx[0] == 0 && rx[1] == 0, "R4 zero length crc", {rx[0], rx[1]}, 0);
            if (len % 5 == 0) begin
                for (int i = 0; i < 80; i++) rx_prev[i] = rx[i];
                handshake(0);
                chk(stat_idle == 0 && stat_have == (len > 0), "R7 still armed",
                    {stat_idle, stat_have}, len > 0);
                expect_packet(ep, len, len + 1, "R7 resend", n);
                for (int i = 0; i < len + 2; i++)
                    if (rx[i] !== rx_prev[i]) chk(0, "R7 resend identical", rx[i], rx_prev[i]);
            end
            handshake(1);
            chk(stat_idle == 1 && stat_have == 0, "R8 emptied", {stat_idle, stat_have}, 2);
            chk(ev_pend == 1, "R8 done pending", ev_pend, 1);
            pend_wr = 1; pend_wdata = 1;
            @(negedge clk);
            pend_wr = 0;
            chk(ev_pend == 0, "R9 pending cleared", ev_pend, 0);
        end

        // R1 overflow: 70 writes keep only the first 64
        for (int i = 0; i < 70; i++) put(pat(64, i));
        ctl(4'd9, 0, 0);
        expect_packet(4'd9, 64, 2, "R1 overflow", n);
        handshake(1);

        // R9 enable and write-one-to-clear
        chk(irq == 0, "R9 irq masked", irq, 0);
        en_wr = 1; en_wdata = 1;
        @(negedge clk);
        en_wr = 0;
        chk(irq == 1, "R9 irq enabled", irq, 1);
        pend_wr = 1; pend_wdata = 0;
        @(negedge clk);
        pend_wr = 0;
        chk(ev_pend == 1 && irq == 1, "R9 zero write ignored", {ev_pend, irq}, 3);
        pend_wr = 1; pend_wdata = 1;
        @(negedge clk);
        pend_wr = 0;
        chk(irq == 0, "R9 irq cleared", irq, 0);

        // R10 stall overrides armed data, R11 setup clears it
        for (int i = 0; i < 7; i++) put(pat(7, i));
        ctl(4'd3, 0, 0);
        ctl(4'd3, 0, 1);
        chk(stat_idle == 0 && stat_have == 1, "R10 stall keeps arming", {stat_idle, stat_have}, 1);
        token(4'd3, got, kind);
        chk(got && kind == 2'd1, "R10 armed but stalled", kind, 1);
        chk(tx_valid == 0, "R10 no stream after STALL", tx_valid, 0);
        ctl(4'd5, 0, 1);
        token(4'd5, got, kind);
        chk(got && kind == 2'd1, "R10 unarmed stalled", kind, 1);
        setup(4'd3);
        expect_packet(4'd3, 7, 0, "R11 after setup", n);
        handshake(1);
        token(4'd5, got, kind);
        chk(got && kind == 2'd1, "R11 other stall kept", kind, 1);
        ctl(4'd5, 0, 0);
        expect_packet(4'd5, 0, 1, "R10 unstall arms", n);
        handshake(1);
        pend_wr = 1; pend_wdata = 1;
        @(negedge clk);
        pend_wr = 0;

        // R12 flush empties and disarms, also mid-packet
        for (int i = 0; i < 5; i++) put(pat(5, i));
        ctl(4'd2, 0, 0);
        ctl(4'd0, 1, 0);
        chk(stat_idle == 1 && stat_have == 0, "R12 flushed", {stat_idle, stat_have}, 2);
        token(4'd2, got, kind);
        chk(got && kind == 2'd0, "R12 NAK after flush", kind, 0);
        for (int i = 0; i < 9; i++) put(pat(9, i));
        ctl(4'd6, 0, 0);
        token(4'd6, got, kind);
        chk(kind == 2'd2, "R12 data before abort", kind, 2);
        ctl(4'd0, 1, 0);
        chk(tx_valid == 0 && stat_have == 0, "R12 abort stream", {tx_valid, stat_have}, 0);
        chk(ev_pend == 0, "R12 no done on abort", ev_pend, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule